// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller

This block keeps a five-bit interrupt request register and an eight-bit interrupt enable register, and names the one source that should be serviced next. There are five sources: vertical blank, display status, timer, serial and joypad. Each source raises its request bit with a single-cycle pulse. The CPU clears a bit by pulsing the matching acknowledge line when it takes that interrupt.

Both registers sit on a small synchronous register port at two fixed addresses. Firmware can read them, and can also write them to raise or drop requests by hand. Every cycle the block ANDs the requests with the enables. It then presents the highest-priority survivor as a one-hot code, or zero when nothing survives. The CPU's dispatch logic consumes this code.

Top module: `irq_prio_ctrl`

## Requirements
- R1: During and directly after a synchronous active-high reset, all request bits, all enable bits, `sel_o` and `rdata_o` are zero.
- R2: A write to address 0xFF0F loads `wdata_i[4:0]` into the request register. Reading 0xFF0F returns the request bits in [4:0] with bits [7:5] read as 1. Read data is registered: `rdata_o` reflects the address and the register contents of the previous cycle.
- R3: A write to address 0xFFFF stores all 8 bits of `wdata_i` in the enable register, and a read of 0xFFFF returns all 8 bits.
- R4: A pulse on `req_i[k]` sets request bit k. The bit positions are: vertical blank = 0, display status = 1, timer = 2, serial = 3, joypad = 4.
- R5: A pulse on `ack_i[k]` clears request bit k and leaves the other request bits unchanged.
- R6: `sel_o` is registered and one-hot. One cycle after the registers hold a pending set (requests AND enable[4:0]), `sel_o` carries the lowest-numbered pending bit. The priority order is therefore vertical blank, display status, timer, serial, joypad.
- R7: `sel_o` is zero whenever the pending set was empty the cycle before. Enable bits [7:5] never make a source pending.
- R8: When a request pulse and a request-register write fall in the same cycle, the requested bit ends up set whatever value is written.
- R9: When an acknowledge and a request for the same source fall in the same cycle, that bit ends up set.
- R10: Any other address reads as 0xFF, and a write to it changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 5 | Per-source request pulses |
| ack_i | input | 5 | Per-source acknowledge (clear) pulses from the CPU |
| addr_i | input | 16 | Register port address |
| we_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Registered read data for the previous cycle's address |
| sel_o | output | 5 | One-hot selected interrupt source, or zero |

## Verification
The assertions check, on every cycle, the properties that hold no matter what the stimulus is:
- a request always lands in its bit;
- an acknowledge without a competing request clears its bit;
- a write stores the right bits;
- `sel_o` stays one-hot or zero, is always a member of the previous pending set, and is never zero when that set was non-empty.

Some behaviour depends on the exact value that should appear, and only the bench's scenarios compared against its reference model can show it. This covers the precise priority order, the forced-high read bits, the open-bus value at other addresses, and the outcome of request-versus-write and request-versus-acknowledge collisions.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 16;

  typedef enum logic [2:0] {
    SRC_VBLANK = 3'd0,
    SRC_STAT   = 3'd1,
    SRC_TIMER  = 3'd2,
    SRC_SERIAL = 3'd3,
    SRC_JOYPAD = 3'd4
  } irq_src_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] req,
  input  logic [N-1:0] ack,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] flag_d;

  // Write first, then acknowledge, then request: a request always survives.
  always_comb begin
    flag_d = we ? wdata : flag_q;
    flag_d = flag_d & ~ack;
    flag_d = flag_d | req;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= flag_d;
  end

  p_req_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |=> ((flag_q & $past(req)) == $past(req)));

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
    ((ack & ~req) != '0) |=> ((flag_q & $past(ack & ~req)) == '0));

  p_write_stores_r2: assert property (@(posedge clk) disable iff (rst)
    (we && req == '0 && ack == '0) |=> (flag_q == $past(wdata)));
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst)     en_q <= '0;
    else if (we) en_q <= wdata;
  end

  p_en_store_r3: assert property (@(posedge clk) disable iff (rst)
    we |=> (en_q == $past(wdata)));

  p_en_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(en_q));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] pend,
  output logic [N-1:0] grant
);
  // lower_any[i] is high when any bit below i is pending
  logic [N:0] lower_any;
  assign lower_any[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign lower_any[i+1] = lower_any[i] | pend[i];
    assign grant[i]       = pend[i] & ~lower_any[i];
  end

  always_comb begin
    assert ($onehot0(grant)) else $error("p_grant_onehot_r6");
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int          N_SRC     = NUM_SRC,
  parameter int          DW        = DATA_W,
  parameter int          AW        = ADDR_W,
  parameter logic [15:0] FLAG_ADDR = 16'hFF0F,
  parameter logic [15:0] EN_ADDR   = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] ack_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             we_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [N_SRC-1:0] sel_o
);
  localparam int PAD_W = DW - N_SRC;

  logic             hit_flag, hit_en;
  logic [N_SRC-1:0] flag_q, pend, grant;
  logic [DW-1:0]    en_q, rd_d;

  assign hit_flag = (addr_i == AW'(FLAG_ADDR));
  assign hit_en   = (addr_i == AW'(EN_ADDR));

  irq_flag_bank #(.N(N_SRC)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .we     (we_i & hit_flag),
    .wdata  (wdata_i[N_SRC-1:0]),
    .req    (req_i),
    .ack    (ack_i),
    .flag_q (flag_q)
  );

  irq_enable_reg #(.W(DW)) u_enable (
    .clk   (clk),
    .rst   (rst),
    .we    (we_i & hit_en),
    .wdata (wdata_i),
    .en_q  (en_q)
  );

  assign pend = flag_q & en_q[N_SRC-1:0];

  irq_prio_pick #(.N(N_SRC)) u_pick (
    .pend  (pend),
    .grant (grant)
  );

  always_comb begin
    if (hit_flag)    rd_d = {{PAD_W{1'b1}}, flag_q};
    else if (hit_en) rd_d = en_q;
    else             rd_d = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o   <= '0;
      rdata_o <= '0;
    end else begin
      sel_o   <= grant;
      rdata_o <= rd_d;
    end
  end

  p_sel_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_o));

  p_sel_in_pend_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sel_o & ~$past(pend)) == '0));

  p_sel_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    (pend != '0) |=> (sel_o != '0));

  p_sel_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |=> (sel_o == '0));
endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  req_i, ack_i;
  logic [15:0] addr_i;
  logic        we_i;
  logic [7:0]  wdata_i;
  logic [7:0]  rdata_o;
  logic [4:0]  sel_o;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  logic [4:0] m_flag;
  logic [7:0] m_en, m_rd;
  logic [4:0] m_sel;

  always #10 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst(rst), .req_i(req_i), .ack_i(ack_i), .addr_i(addr_i),
    .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .sel_o(sel_o)
  );

  // Behavioural reference model, updated at each rising edge.
  always @(posedge clk) begin
    logic [4:0] p;
    if (rst) begin
      m_flag = '0; m_en = '0; m_rd = '0; m_sel = '0;
    end else begin
      if (addr_i == 16'hFF0F)      m_rd = {3'b111, m_flag};
      else if (addr_i == 16'hFFFF) m_rd = m_en;
      else                         m_rd = 8'hFF;
      p = m_flag & m_en[4:0];
      m_sel = '0;
      for (int i = 4; i >= 0; i--) if (p[i]) m_sel = 5'(1 << i);
      if (we_i && addr_i == 16'hFF0F) m_flag = wdata_i[4:0];
      m_flag = m_flag & ~ack_i;
      m_flag = m_flag | req_i;
      if (we_i && addr_i == 16'hFFFF) m_en = wdata_i;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare on every cycle, away from the rising edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(cur_req, {3'b000, sel_o}, {3'b000, m_sel}, "sel_o");
      check(cur_req, rdata_o, m_rd, "rdata_o");
    end
  end

  task automatic cyc(input logic [4:0] rq, input logic [4:0] ak, input logic [15:0] a,
                     input logic w, input logic [7:0] d);
    @(negedge clk);
    #1;
    req_i = rq; ack_i = ak; addr_i = a; we_i = w; wdata_i = d;
  endtask

  task automatic idle(input logic [15:0] a, input int n);
    for (int i = 0; i < n; i++) cyc(5'd0, 5'd0, a, 1'b0, 8'h00);
  endtask

  initial begin
    #1000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1; req_i = 0; ack_i = 0; addr_i = 16'hFF0F; we_i = 0; wdata_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state seen at the ports
    check("R1", {3'b000, sel_o}, 8'h00, "sel_o in reset");
    check("R1", rdata_o, 8'h00, "rdata_o in reset");
    #1 rst = 0;
    cur_req = "R1"; idle(16'hFF0F, 2);

    cur_req = "R3"; cyc(0, 0, 16'hFFFF, 1, 8'hA5); idle(16'hFFFF, 2);
    cyc(0, 0, 16'hFFFF, 1, 8'hE0); idle(16'hFFFF, 2);
    cur_req = "R2"; cyc(0, 0, 16'hFF0F, 1, 8'hFF); idle(16'hFF0F, 2);
    cyc(0, 0, 16'hFF0F, 1, 8'h0A); idle(16'hFF0F, 2);
    cyc(0, 0, 16'hFF0F, 1, 8'h00); idle(16'hFF0F, 2);

    cur_req = "R7"; // only enable bits 7:5 set: nothing pending
    cyc(5'h1F, 0, 16'hFF0F, 0, 0); idle(16'hFF0F, 3);

    cur_req = "R6"; cyc(0, 0, 16'hFFFF, 1, 8'h1F); idle(16'hFF0F, 2);
    cur_req = "R5";
    for (int k = 0; k < 5; k++) begin
      cyc(0, 5'(1 << k), 16'hFF0F, 0, 0); idle(16'hFF0F, 2);
    end

    cur_req = "R4";
    for (int k = 4; k >= 0; k--) begin
      cyc(5'(1 << k), 0, 16'hFF0F, 0, 0); idle(16'hFF0F, 2);
    end

    cur_req = "R6"; cyc(0, 0, 16'hFFFF, 1, 8'h16); idle(16'hFF0F, 2);
    cyc(0, 0, 16'hFFFF, 1, 8'h18); idle(16'hFF0F, 2);

    cur_req = "R8"; cyc(0, 0, 16'hFFFF, 1, 8'h1F);
    cyc(5'h04, 0, 16'hFF0F, 1, 8'h00); idle(16'hFF0F, 2);
    cyc(5'h01, 0, 16'hFF0F, 1, 8'h10); idle(16'hFF0F, 2);

    cur_req = "R9"; cyc(5'h08, 5'h08, 16'hFF0F, 0, 0); idle(16'hFF0F, 2);
    cyc(5'h02, 5'h11, 16'hFF0F, 0, 0); idle(16'hFF0F, 2);

    cur_req = "R10"; cyc(0, 0, 16'h1234, 1, 8'h00); idle(16'h1234, 2);
    cyc(0, 0, 16'hFF0E, 1, 8'h00); idle(16'hFFFF, 2); idle(16'hFF0F, 2);

    cur_req = "R6"; cyc(0, 5'h1F, 16'hFF0F, 0, 0); idle(16'hFF0F, 2);
    for (int k = 0; k < 40; k++) begin
      cyc(5'((k * 7) % 32), 5'((k * 13) % 32), (k % 3 == 0) ? 16'hFFFF : 16'hFF0F,
          (k % 5 == 0), 8'((k * 37) % 256));
    end
    idle(16'hFF0F, 3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule